// File: doc/BRIEF.md
# Asynchronous Static RAM Cycle Controller

This block sits between on-chip logic and an external asynchronous static RAM with 17 address bits and a shared 8-bit data bus. It takes single read or write requests and turns each one into a sequence of pin levels. Each phase of that sequence lasts a programmable number of clock cycles. The phases are: device select with the address applied, the write strobe or the read access window, data hold after the strobe, and a completion cycle. The controller drives an active-low enable, an active-high select, an active-low write strobe, an active-low output enable, the address, and a data driver made of an output value plus a drive-enable. It reads the RAM's data pins back through a separate input.

Requests arrive on a valid/ready handshake. A request transfers on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is high only while the controller is idle, so the requester must hold its request until it is taken. The request fields may change freely while `req_ready` is low, and the controller ignores them. Completion is a one-cycle `rsp_valid` pulse with no back-pressure. For reads, `rsp_rdata` is valid in that cycle.

The design avoids two hazards. First, the address and write data never change while the device is enabled, so the address never moves during an active strobe. Second, output enable stays inactive for the whole of every write, and the controller drives the data bus only while output enable is inactive, so the bus never has two drivers.

Top module: `async_sram_ctrl`

## Requirements
- R1: While `rst_n` is low: `mem_ce_n`=1, `mem_cs`=0, `mem_we_n`=1, `mem_oe_n`=1, `mem_dq_oe`=0, `rsp_valid`=0 and `req_ready`=1.
- R2: A request transfers only on an edge with `req_valid` and `req_ready` both high. `req_ready` is low from the cycle after the transfer through the completion cycle. Requests presented while `req_ready` is low have no effect on any pin or on memory contents.
- R3: A write (`req_write`=1) runs SETUP_CYC cycles with `mem_ce_n`=0, `mem_cs`=1 and `mem_we_n`=1. It then runs WRPULSE_CYC cycles with `mem_we_n`=0, then HOLD_CYC cycles with `mem_we_n`=1 and the device still selected. It then runs one completion cycle with `mem_ce_n`=1 and `mem_cs`=0.
- R4: `mem_oe_n` stays 1 in every cycle of a write.
- R5: `mem_dq_oe` is 1 exactly during the write strobe and hold cycles. It is never 1 while `mem_oe_n` is 0.
- R6: `mem_addr` holds the accepted address while `mem_ce_n` is 0. `mem_dq_out` holds the accepted write data while `mem_dq_oe` is 1.
- R7: A read (`req_write`=0) runs SETUP_CYC cycles selected with `mem_oe_n`=1. It then runs ACCESS_CYC cycles with `mem_oe_n`=0 and `mem_we_n`=1. `mem_dq_in` is captured in the last access cycle and appears on `rsp_rdata` in the completion cycle.
- R8: `rsp_valid` is 1 for exactly the one completion cycle of each request, and `req_ready` returns to 1 in the following cycle.
- R9: Whenever the controller is idle (`req_ready`=1), the device is deselected: `mem_ce_n`=1 and `mem_cs`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Controller idle, request can transfer |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Target address |
| req_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 8 | Read data, valid with rsp_valid on reads |
| mem_addr | output | 17 | RAM address |
| mem_ce_n | output | 1 | RAM enable, active low |
| mem_cs | output | 1 | RAM select, active high |
| mem_we_n | output | 1 | RAM write strobe, active low |
| mem_oe_n | output | 1 | RAM output enable, active low |
| mem_dq_out | output | 8 | Value driven onto the data bus |
| mem_dq_oe | output | 1 | Data bus driver enable |
| mem_dq_in | input | 8 | Value read from the data bus |

## Verification
The bench models the RAM behaviourally and runs a cycle-accurate reference model that predicts every pin on every cycle. It writes to the lowest and highest addresses with all-zero and all-one data, which separates address and data bit errors from sequencing errors. Reads back of those locations, of a never-written location, and of a location rewritten just before the read confirm that data is captured in the right access cycle. Back-to-back requests with `req_valid` held high exercise the idle-to-accept turnaround. Junk requests offered while the controller is busy, followed by read-back, show that requests outside idle are ignored.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;
  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_SETUP  = 3'd1,
    PH_STROBE = 3'd2,
    PH_HOLD   = 3'd3,
    PH_DONE   = 3'd4
  } phase_t;

  function automatic int max4(input int a, input int b, input int c, input int d);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction
endpackage

// File: rtl/sram_req_hold.sv
module sram_req_hold #(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic              in_write,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [DATA_W-1:0] in_wdata,
  output logic              op_write,
  output logic [ADDR_W-1:0] op_addr,
  output logic [DATA_W-1:0] op_wdata
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_write <= 1'b0;
      op_addr  <= '0;
      op_wdata <= '0;
    end else if (take) begin
      op_write <= in_write;
      op_addr  <= in_addr;
      op_wdata <= in_wdata;
    end
  end
endmodule

// File: rtl/sram_phase_seq.sv
module sram_phase_seq
  import sram_ctrl_pkg::*;
#(
  parameter int SETUP_CYC   = 2,
  parameter int WRPULSE_CYC = 3,
  parameter int HOLD_CYC    = 1,
  parameter int ACCESS_CYC  = 3
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   take,
  input  logic   op_write,
  output phase_t phase,
  output logic   phase_last
);
  localparam int MAXC  = max4(SETUP_CYC, WRPULSE_CYC, HOLD_CYC, ACCESS_CYC);
  localparam int CNT_W = (MAXC > 1) ? $clog2(MAXC) : 1;
  localparam logic [CNT_W-1:0] LD_SETUP = CNT_W'(SETUP_CYC - 1);
  localparam logic [CNT_W-1:0] LD_WR    = CNT_W'(WRPULSE_CYC - 1);
  localparam logic [CNT_W-1:0] LD_HOLD  = CNT_W'(HOLD_CYC - 1);
  localparam logic [CNT_W-1:0] LD_ACC   = CNT_W'(ACCESS_CYC - 1);

  phase_t         ph_q, ph_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  assign phase      = ph_q;
  assign phase_last = (cnt_q == '0);

  always_comb begin
    ph_d  = ph_q;
    cnt_d = (cnt_q == '0) ? cnt_q : cnt_q - 1'b1;
    unique case (ph_q)
      PH_IDLE: if (take) begin
        ph_d  = PH_SETUP;
        cnt_d = LD_SETUP;
      end
      PH_SETUP: if (cnt_q == '0) begin
        ph_d  = PH_STROBE;
        cnt_d = op_write ? LD_WR : LD_ACC;
      end
      PH_STROBE: if (cnt_q == '0) begin
        if (op_write) begin
          ph_d  = PH_HOLD;
          cnt_d = LD_HOLD;
        end else begin
          ph_d = PH_DONE;
        end
      end
      PH_HOLD: if (cnt_q == '0) ph_d = PH_DONE;
      PH_DONE: ph_d = PH_IDLE;
      default: ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= PH_IDLE;
      cnt_q <= '0;
    end else begin
      ph_q  <= ph_d;
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/sram_pin_map.sv
module sram_pin_map
  import sram_ctrl_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  phase_t            phase,
  input  logic              phase_last,
  input  logic              op_write,
  input  logic [DATA_W-1:0] dq_in,
  output logic              ce_n,
  output logic              cs,
  output logic              we_n,
  output logic              oe_n,
  output logic              dq_oe,
  output logic              done,
  output logic [DATA_W-1:0] rdata
);
  logic selected;

  assign selected = (phase == PH_SETUP) || (phase == PH_STROBE) || (phase == PH_HOLD);

  always_comb begin
    ce_n  = !selected;
    cs    = selected;
    we_n  = !(op_write && phase == PH_STROBE);
    oe_n  = !(!op_write && phase == PH_STROBE);
    dq_oe = op_write && (phase == PH_STROBE || phase == PH_HOLD);
    done  = (phase == PH_DONE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      rdata <= '0;
    else if (phase == PH_STROBE && !op_write && phase_last)
      rdata <= dq_in;
  end
endmodule

// File: rtl/async_sram_ctrl.sv
module async_sram_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W      = 17,
  parameter int DATA_W      = 8,
  parameter int SETUP_CYC   = 2,
  parameter int WRPULSE_CYC = 3,
  parameter int HOLD_CYC    = 1,
  parameter int ACCESS_CYC  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_ce_n,
  output logic              mem_cs,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_in
);
  phase_t phase;
  logic   phase_last;
  logic   take;
  logic   op_write;

  assign req_ready = (phase == PH_IDLE);
  assign take      = req_valid && req_ready;

  sram_req_hold #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_hold (
    .clk(clk), .rst_n(rst_n), .take(take),
    .in_write(req_write), .in_addr(req_addr), .in_wdata(req_wdata),
    .op_write(op_write), .op_addr(mem_addr), .op_wdata(mem_dq_out)
  );

  sram_phase_seq #(
    .SETUP_CYC(SETUP_CYC), .WRPULSE_CYC(WRPULSE_CYC),
    .HOLD_CYC(HOLD_CYC), .ACCESS_CYC(ACCESS_CYC)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .take(take), .op_write(op_write),
    .phase(phase), .phase_last(phase_last)
  );

  sram_pin_map #(.DATA_W(DATA_W)) u_pins (
    .clk(clk), .rst_n(rst_n), .phase(phase), .phase_last(phase_last),
    .op_write(op_write), .dq_in(mem_dq_in),
    .ce_n(mem_ce_n), .cs(mem_cs), .we_n(mem_we_n), .oe_n(mem_oe_n),
    .dq_oe(mem_dq_oe), .done(rsp_valid), .rdata(rsp_rdata)
  );

  assert_busy_after_take_R2: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> !req_ready);

  assert_strobe_selected_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (!mem_ce_n && mem_cs));

  assert_oe_off_in_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_we_n || mem_dq_oe) |-> mem_oe_n);

  assert_no_contention_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_dq_oe && !mem_oe_n));

  assert_addr_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_ce_n && !$past(mem_ce_n)) |-> $stable(mem_addr));

  assert_wdata_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_dq_oe && $past(mem_dq_oe)) |-> $stable(mem_dq_out));

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> (!rsp_valid && req_ready));

  assert_idle_deselect_R9: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_ce_n && !mem_cs && mem_we_n));
endmodule

// File: tb/test_async_sram_ctrl.sv
module test_async_sram_ctrl;
  localparam int S = 2, W = 3, H = 1, A = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [16:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic req_ready, rsp_valid, mem_ce_n, mem_cs, mem_we_n, mem_oe_n, mem_dq_oe;
  logic [7:0] rsp_rdata, mem_dq_out, mem_dq_in;
  logic [16:0] mem_addr;

  int n_chk = 0, n_err = 0, n_rsp = 0, n_req = 0;
  logic [7:0] ram [int];
  logic [7:0] ref_mem [int];

  always #5 clk = ~clk;

  async_sram_ctrl #(.SETUP_CYC(S), .WRPULSE_CYC(W), .HOLD_CYC(H), .ACCESS_CYC(A)) i_async_sram_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mem_addr(mem_addr),
    .mem_ce_n(mem_ce_n), .mem_cs(mem_cs), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
    .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
  );

  // Behavioural RAM: drives only when selected, reading, output enabled.
  always @* begin
    if (rst_n && !mem_ce_n && mem_cs && mem_we_n && !mem_oe_n)
      mem_dq_in = ram.exists(int'(mem_addr)) ? ram[int'(mem_addr)] : 8'h00;
    else
      mem_dq_in = 8'hA5;
  end
  always @(posedge mem_we_n) begin
    if (rst_n && !mem_ce_n && mem_cs && mem_dq_oe) ram[int'(mem_addr)] = mem_dq_out;
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Reference model: phase time since acceptance.
  int m_t = -1, m_last = 0;
  logic m_wr = 1'b0;
  logic [16:0] m_a = '0;
  logic [7:0] m_d = '0, m_rd = '0;

  always @(posedge clk) begin
    if (!rst_n) m_t = -1;
    else if (m_t >= 0) begin
      m_t++;
      if (m_t > m_last) m_t = -1;
    end else if (req_valid) begin
      m_t = 0; m_wr = req_write; m_a = req_addr; m_d = req_wdata;
      m_last = m_wr ? S + W + H : S + A;
      if (m_wr) ref_mem[int'(m_a)] = m_d;
      else m_rd = ref_mem.exists(int'(m_a)) ? ref_mem[int'(m_a)] : 8'h00;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      bit sel, strobe, hold, done, idle;
      idle   = (m_t < 0);
      done   = !idle && (m_t == m_last);
      sel    = !idle && !done;
      strobe = sel && m_t >= S && m_t < S + (m_wr ? W : A);
      hold   = sel && m_wr && m_t >= S + W;
      chk("R2 req_ready", int'(req_ready), int'(idle));
      chk("R9 mem_ce_n", int'(mem_ce_n), int'(!sel));
      chk("R3 mem_cs", int'(mem_cs), int'(sel));
      chk("R3 mem_we_n", int'(mem_we_n), int'(!(m_wr && strobe)));
      if (m_wr && !idle) chk("R4 mem_oe_n", int'(mem_oe_n), 1);
      else chk("R7 mem_oe_n", int'(mem_oe_n), int'(!(strobe && !m_wr)));
      chk("R5 mem_dq_oe", int'(mem_dq_oe), int'(m_wr && (strobe || hold)));
      chk("R8 rsp_valid", int'(rsp_valid), int'(done));
      if (sel) chk("R6 mem_addr", int'(mem_addr), int'(m_a));
      if (m_wr && (strobe || hold)) chk("R6 mem_dq_out", int'(mem_dq_out), int'(m_d));
      if (done && !m_wr) chk("R7 rsp_rdata", int'(rsp_rdata), int'(m_rd));
      if (rsp_valid) n_rsp++;
    end
  end

  task automatic send(input bit w, input logic [16:0] a, input logic [7:0] d);
    bit rdy;
    req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
    forever begin
      @(negedge clk); rdy = req_ready;
      @(posedge clk); #2;
      if (rdy) break;
    end
    n_req++;
  endtask

  task automatic drop();
    req_valid = 1'b0;
  endtask

  task automatic wait_idle();
    drop();
    repeat (12) @(posedge clk);
    #2;
  endtask

  initial begin
    #(200000 * 10);
    n_err++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    chk("R1 mem_ce_n", int'(mem_ce_n), 1);
    chk("R1 mem_cs", int'(mem_cs), 0);
    chk("R1 mem_we_n", int'(mem_we_n), 1);
    chk("R1 mem_oe_n", int'(mem_oe_n), 1);
    chk("R1 mem_dq_oe", int'(mem_dq_oe), 0);
    chk("R1 rsp_valid", int'(rsp_valid), 0);
    chk("R1 req_ready", int'(req_ready), 1);
    @(posedge clk); #2; rst_n = 1'b1;
    @(posedge clk); #2;

    // Back-to-back writes at the address extremes (R3, R6)
    send(1'b1, 17'h00000, 8'h00);
    send(1'b1, 17'h1FFFF, 8'hFF);
    send(1'b1, 17'h12345, 8'h3C);
    send(1'b1, 17'h0ABCD, 8'h5A);
    wait_idle();

    // Reads back, including a never-written location (R7)
    send(1'b0, 17'h1FFFF, 8'h00);
    send(1'b0, 17'h00000, 8'h00);
    send(1'b0, 17'h12345, 8'h00);
    send(1'b0, 17'h00077, 8'h00);
    drop();
    @(posedge clk); #2;

    // Rewrite immediately followed by read of the same location
    send(1'b1, 17'h12345, 8'hC3);
    send(1'b0, 17'h12345, 8'h00);

    // R2: junk offered while busy must be ignored
    req_valid = 1'b1; req_write = 1'b1; req_addr = 17'h0ABCD; req_wdata = 8'hEE;
    repeat (3) @(posedge clk);
    #2; drop();
    wait_idle();
    send(1'b0, 17'h0ABCD, 8'h00);
    send(1'b0, 17'h12345, 8'h00);
    wait_idle();

    // R8: one completion pulse per request
    chk("R8 response count", n_rsp, n_req);

    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule